// File: doc/BRIEF.md
# Event Performance Counter Bank

This block watches a CPU core and counts how often chosen micro-architectural events happen. It holds a bank of general-purpose event counters and one dedicated cycle counter. Each event counter is bound to an 8-bit event code. When the core reports an event whose code matches, the counter adds one, provided counting is enabled. Supported codes are 0x11 for cycles, 0x19 for a bus access, 0x03 for an L1 data refill, 0x04 for an L1 data access, 0x10 for a mispredicted branch, 0x16 for an L2 data access and 0x17 for an L2 data refill. Other 8-bit codes can be stored but no source produces them.

Software reaches the counters indirectly through a small register file. It first writes an index to the select register. Later event-type writes and counter-value reads then act on that counter. Enables are set-only. A control register holds the global enable and carries the clear commands. Counters wrap on overflow and leave sticky flags in an overflow register.

The core reports events as a valid strobe plus a code, one event per clock. There is no ready signal. A monitor must never stall the core, so every valid event is taken in the cycle it is presented. The register port is a plain single-cycle write strobe with a combinational read. No back-pressure exists on either side.

Register addresses are: 0 select, 1 event type, 2 enable-set, 3 control, 4 counter value, 5 overflow status, 6 cycle count.

Top module: `perf_event_bank`

## Requirements
- R1: After reset, every counter, counter enable, overflow flag and the global enable read as zero.
- R2: Writing an index 0 to 5 to the select register (address 0) makes that counter the target of event-type writes and reads (address 1) and of counter-value reads (address 4).
- R3: An event counter adds one on a clock edge only when all of the following hold in that cycle: the global enable is set, its own enable is set, evt_valid is high, and evt_code equals its stored code.
- R4: A write to the enable-set register (address 2) sets counter enable n for each data bit n that is 1. Bits written as 0 leave their enable unchanged. Reading address 2 returns the enable bits.
- R5: A write to the control register (address 3) behaves as follows. Data bit 0 becomes the global enable, which is readable at bit 0 of address 3. Data bit 1 clears every event counter. Data bit 2 clears the cycle counter.
- R6: If a clear of the event counters and a matching event land in the same cycle, the clear wins and the counter reads zero in the next cycle.
- R7: An event counter at its maximum value that receives a counted event wraps to zero and sets bit n of the overflow register (address 5). The flag stays set until software writes 1 to that bit. Writing 0 to it has no effect.
- R8: When the select register holds a value above 5, event-type writes change no counter's code, and reads of addresses 1 and 4 return zero.
- R9: The cycle counter (address 6) adds one on every clock edge while the global enable is set and holds its value otherwise. Its wrap flag is overflow bit 6.
- R10: The effect of a register write or an event is visible on rd_data in the cycle after the clock edge that takes it. rd_data follows rd_addr with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | REG_W | Register read data (combinational) |
| evt_valid | input | 1 | An event is reported this cycle |
| evt_code | input | EVT_W | Code of the reported event |

## Verification
Every register write and every event takes effect at the clock edge that samples it. The result therefore appears on rd_data one cycle later, and a read shows it with no further delay. The bench drives each operation at a falling edge and lets one rising edge pass. It then samples rd_data just after the next falling edge. This places each check in the first cycle where the new value is due. The cycle counter is checked by difference: two reads a known number of rising edges apart must differ by exactly that number while enabled, and by zero while disabled.

// File: rtl/perf_pkg.sv
package perf_pkg;
  typedef enum logic [2:0] {
    REG_SEL   = 3'd0,
    REG_TYPE  = 3'd1,
    REG_ENSET = 3'd2,
    REG_CTRL  = 3'd3,
    REG_VALUE = 3'd4,
    REG_OVF   = 3'd5,
    REG_CYCLE = 3'd6
  } perf_reg_e;

  localparam int CTRL_RUN_BIT     = 0;
  localparam int CTRL_CLR_EVT_BIT = 1;
  localparam int CTRL_CLR_CYC_BIT = 2;
endpackage

// File: rtl/perf_event_ctr.sv
module perf_event_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic wrap;
  assign wrap = inc && !clr && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (wrap)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> cnt == $past(cnt) + W'(1));
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
  assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt == {W{1'b1}}) |=> ovf);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/perf_ctl_regs.sv
module perf_ctl_regs
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 6,
  parameter int EVT_W   = 8,
  parameter int REG_W   = 32,
  localparam int SEL_W  = $clog2(NUM_CTR)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [2:0]                      wr_addr,
  input  logic [REG_W-1:0]                wr_data,
  output logic [SEL_W-1:0]                sel,
  output logic                            sel_ok,
  output logic [NUM_CTR-1:0][EVT_W-1:0]   codes,
  output logic [NUM_CTR-1:0]              ctr_en,
  output logic                            run,
  output logic                            clr_evt,
  output logic                            clr_cyc,
  output logic [NUM_CTR:0]                ovf_clr
);
  logic wr_sel, wr_type, wr_ens, wr_ctl, wr_ovf;
  assign wr_sel  = wr_en && (wr_addr == REG_SEL);
  assign wr_type = wr_en && (wr_addr == REG_TYPE);
  assign wr_ens  = wr_en && (wr_addr == REG_ENSET);
  assign wr_ctl  = wr_en && (wr_addr == REG_CTRL);
  assign wr_ovf  = wr_en && (wr_addr == REG_OVF);

  assign clr_evt = wr_ctl && wr_data[CTRL_CLR_EVT_BIT];
  assign clr_cyc = wr_ctl && wr_data[CTRL_CLR_CYC_BIT];
  assign ovf_clr = wr_ovf ? wr_data[NUM_CTR:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel    <= '0;
      sel_ok <= 1'b1;
      ctr_en <= '0;
      run    <= 1'b0;
    end else begin
      if (wr_sel) begin
        sel    <= wr_data[SEL_W-1:0];
        sel_ok <= wr_data < REG_W'(NUM_CTR);
      end
      if (wr_ens) ctr_en <= ctr_en | wr_data[NUM_CTR-1:0];
      if (wr_ctl) run <= wr_data[CTRL_RUN_BIT];
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_code
    always_ff @(posedge clk) begin
      if (!rst_n) codes[i] <= '0;
      else if (wr_type && sel_ok && sel == SEL_W'(i)) codes[i] <= wr_data[EVT_W-1:0];
    end
  end

  assert_enable_set_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ctr_en & $past(ctr_en)) == $past(ctr_en));
  assert_bad_sel_no_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_type && !sel_ok) |=> $stable(codes));
endmodule

// File: rtl/perf_event_bank.sv
module perf_event_bank
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 6,
  parameter int CTR_W   = 32,
  parameter int CYC_W   = 32,
  parameter int EVT_W   = 8,
  parameter int REG_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             evt_valid,
  input  logic [EVT_W-1:0] evt_code
);
  localparam int SEL_W = $clog2(NUM_CTR);

  logic [SEL_W-1:0]              sel;
  logic                          sel_ok;
  logic [NUM_CTR-1:0][EVT_W-1:0] codes;
  logic [NUM_CTR-1:0]            ctr_en;
  logic                          run;
  logic                          clr_evt, clr_cyc;
  logic [NUM_CTR:0]              ovf_clr;
  logic [NUM_CTR:0]              ovf_vec;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_arr;
  logic [NUM_CTR-1:0]            hit;
  logic [CYC_W-1:0]              cyc_cnt;

  perf_ctl_regs #(.NUM_CTR(NUM_CTR), .EVT_W(EVT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel(sel), .sel_ok(sel_ok), .codes(codes), .ctr_en(ctr_en), .run(run),
    .clr_evt(clr_evt), .clr_cyc(clr_cyc), .ovf_clr(ovf_clr)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign hit[i] = run && ctr_en[i] && evt_valid && (evt_code == codes[i]);
    perf_event_ctr #(.W(CTR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(hit[i]), .clr(clr_evt),
      .ovf_clr(ovf_clr[i]), .cnt(cnt_arr[i]), .ovf(ovf_vec[i])
    );
  end

  perf_event_ctr #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .inc(run), .clr(clr_cyc),
    .ovf_clr(ovf_clr[NUM_CTR]), .cnt(cyc_cnt), .ovf(ovf_vec[NUM_CTR])
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_SEL:   rd_data = REG_W'(sel);
      REG_TYPE:  if (sel_ok) rd_data = REG_W'(codes[sel]);
      REG_ENSET: rd_data = REG_W'(ctr_en);
      REG_CTRL:  rd_data = REG_W'(run);
      REG_VALUE: if (sel_ok) rd_data = REG_W'(cnt_arr[sel]);
      REG_OVF:   rd_data = REG_W'(ovf_vec);
      REG_CYCLE: rd_data = REG_W'(cyc_cnt);
      default:   rd_data = '0;
    endcase
  end

  assert_bad_sel_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && (rd_addr == REG_VALUE || rd_addr == REG_TYPE)) |-> rd_data == '0);
  assert_no_count_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr_evt) |=> $stable(cnt_arr));
endmodule

// File: tb/test_perf_event_bank.sv
`timescale 1ns/1ps
module test_perf_event_bank;
  localparam int CTR_W = 8;
  localparam int OP_WR = 0, OP_EV = 1, OP_RD = 2, OP_NV = 3;
  localparam int A_SEL = 0, A_TYPE = 1, A_ENS = 2, A_CTRL = 3, A_VAL = 4, A_OVF = 5, A_CYC = 6;
  localparam int NV = 41;
  // fields: req[72:69] op[68:67] addr[66:64] data[63:32] exp[31:0]
  localparam logic [72:0] TBL [NV] = '{
    {4'd2, 2'd0, 3'd0, 32'h0,  32'h0},  // R2 select 0
    {4'd2, 2'd0, 3'd1, 32'h03, 32'h0},
    {4'd2, 2'd0, 3'd0, 32'h1,  32'h0},
    {4'd2, 2'd0, 3'd1, 32'h04, 32'h0},
    {4'd2, 2'd0, 3'd0, 32'h2,  32'h0},
    {4'd2, 2'd0, 3'd1, 32'h19, 32'h0},
    {4'd4, 2'd0, 3'd2, 32'h3,  32'h0},  // R4 enable 0,1
    {4'd5, 2'd0, 3'd3, 32'h3,  32'h0},  // R5 run and clear
    {4'd3, 2'd1, 3'd0, 32'h03, 32'h0},
    {4'd3, 2'd1, 3'd0, 32'h03, 32'h0},
    {4'd3, 2'd1, 3'd0, 32'h04, 32'h0},
    {4'd3, 2'd1, 3'd0, 32'h19, 32'h0},  // R3 ctr2 not enabled
    {4'd3, 2'd1, 3'd0, 32'h10, 32'h0},
    {4'd3, 2'd0, 3'd0, 32'h0,  32'h0},
    {4'd3, 2'd2, 3'd4, 32'h0,  32'h2},
    {4'd3, 2'd0, 3'd0, 32'h1,  32'h0},
    {4'd3, 2'd2, 3'd4, 32'h0,  32'h1},
    {4'd3, 2'd0, 3'd0, 32'h2,  32'h0},
    {4'd3, 2'd2, 3'd4, 32'h0,  32'h0},
    {4'd4, 2'd0, 3'd2, 32'h4,  32'h0},  // R4 zeros keep 0,1
    {4'd4, 2'd2, 3'd2, 32'h0,  32'h7},
    {4'd4, 2'd1, 3'd0, 32'h19, 32'h0},
    {4'd4, 2'd2, 3'd4, 32'h0,  32'h1},
    {4'd2, 2'd0, 3'd0, 32'h0,  32'h0},
    {4'd2, 2'd2, 3'd1, 32'h0,  32'h03},
    {4'd8, 2'd0, 3'd0, 32'h8,  32'h0},  // R8 bad select
    {4'd8, 2'd2, 3'd4, 32'h0,  32'h0},
    {4'd8, 2'd2, 3'd1, 32'h0,  32'h0},
    {4'd8, 2'd0, 3'd1, 32'h10, 32'h0},
    {4'd8, 2'd0, 3'd0, 32'h0,  32'h0},
    {4'd8, 2'd2, 3'd1, 32'h0,  32'h03},
    {4'd8, 2'd2, 3'd4, 32'h0,  32'h2},
    {4'd5, 2'd0, 3'd3, 32'h0,  32'h0},  // R5 stop
    {4'd3, 2'd1, 3'd0, 32'h03, 32'h0},
    {4'd3, 2'd2, 3'd4, 32'h0,  32'h2},
    {4'd5, 2'd2, 3'd3, 32'h0,  32'h0},
    {4'd5, 2'd0, 3'd3, 32'h1,  32'h0},
    {4'd3, 2'd1, 3'd0, 32'h03, 32'h0},
    {4'd3, 2'd2, 3'd4, 32'h0,  32'h3},
    {4'd3, 2'd3, 3'd0, 32'h03, 32'h0},  // R3 valid low
    {4'd3, 2'd2, 3'd4, 32'h0,  32'h3}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, evt_valid = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [7:0] evt_code = '0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] c0;

  always #5 clk = ~clk;

  perf_event_bank #(.NUM_CTR(6), .CTR_W(CTR_W), .CYC_W(32), .EVT_W(8), .REG_W(32)) i_perf_event_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_valid(evt_valid), .evt_code(evt_code)
  );

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic ev(input logic [7:0] c, input logic v);
    @(negedge clk); evt_valid = v; evt_code = c;
    @(posedge clk); #1 evt_valid = 1'b0;
  endtask

  task automatic chk(input int a, input logic [31:0] e, input string req);
    @(negedge clk); rd_addr = 3'(a); #1;
    n_chk++;
    if (rd_data !== e) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, e);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(A_VAL, 0, "R1"); chk(A_OVF, 0, "R1"); chk(A_ENS, 0, "R1");
    chk(A_CTRL, 0, "R1"); chk(A_CYC, 0, "R1");

    for (int k = 0; k < NV; k++) begin
      logic [72:0] r;
      r = TBL[k];
      case (int'(r[68:67]))
        OP_WR: wr(int'(r[66:64]), r[63:32]);
        OP_EV: ev(r[39:32], 1'b1);
        OP_NV: ev(r[39:32], 1'b0);
        default: chk(int'(r[66:64]), r[31:0], $sformatf("R%0d", r[72:69]));
      endcase
    end

    // R7 wrap and sticky flag; counter 0 holds 3, code 0x03
    for (int k = 0; k < 252; k++) ev(8'h03, 1'b1);
    chk(A_VAL, 255, "R7"); chk(A_OVF, 0, "R7");
    ev(8'h03, 1'b1);
    chk(A_VAL, 0, "R7"); chk(A_OVF, 1, "R7");
    ev(8'h03, 1'b1);
    chk(A_VAL, 1, "R7"); chk(A_OVF, 1, "R7");
    wr(A_OVF, 0); chk(A_OVF, 1, "R7");
    wr(A_OVF, 1); chk(A_OVF, 0, "R7");

    // R6 clear beats same-cycle event
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(A_CTRL); wr_data = 32'h3; evt_valid = 1'b1; evt_code = 8'h03;
    @(posedge clk); #1 wr_en = 1'b0; evt_valid = 1'b0;
    chk(A_VAL, 0, "R6");
    wr(A_SEL, 1); chk(A_VAL, 0, "R5");

    // R9 cycle counter
    @(negedge clk); rd_addr = 3'(A_CYC); #1 c0 = rd_data;
    repeat (5) @(posedge clk);
    chk(A_CYC, c0 + 5, "R9");
    wr(A_CTRL, 0);
    @(negedge clk); rd_addr = 3'(A_CYC); #1 c0 = rd_data;
    repeat (3) @(posedge clk);
    chk(A_CYC, c0, "R9");
    wr(A_CTRL, 4); chk(A_CYC, 0, "R5");

    // R10 combinational read follows address
    @(negedge clk); rd_addr = 3'(A_ENS); #1;
    n_chk++;
    if (rd_data !== 32'h7) begin
      n_fail++;
      $display("FAIL R10 actual=%h expected=%h", rd_data, 32'h7);
    end
    summary();
  end
endmodule